// File: doc/BRIEF.md
# ISA Memory Forwarding Decoder

This block judges every memory cycle started by an ISA master or a DMA channel on a 24-bit address bus. It decides whether the cycle should be passed upward to the PCI side. Two mechanisms shape the decision. The first is a mask of eight 16 KB expansion-ROM windows just below 1 MB, each of which can be opened for forwarding on its own. The second is a programmable hole above 1 MB. The hole has 64 KB granularity, and cycles that land inside it stay on the ISA side.

Three 8-bit configuration bytes hold the window mask and the two hole bounds. They sit behind a byte-wide read/write port. A cycle is presented with a one-cycle valid strobe. One clock later the block returns the captured address, the forward decision and two flags, one saying a ROM window matched and one saying the hole matched.

Top module: `isa_mem_fwd_decode`

## Requirements
- R1: After reset the window mask reads 00h, the hole bottom reads 10h, the hole top reads 0Fh, and `dec_valid` is low.
- R2: The port reaches the window mask at offset 49h, the hole bottom at 4Ah and the hole top at 4Bh. A write presented with `cfg_we` high is returned by `cfg_rdata` from the next clock on.
- R3: Reads of any other offset return 00h, and writes to other offsets change no register.
- R4: Mask bit n opens the 16 KB window from 0C0000h + n×4000h to 0C3FFFh + n×4000h, with n from 0 to 7. A cycle in an open window gives `dec_rom_hit`=1 and `dec_fwd`=1.
- R5: A cycle below 100000h that is not in an open window is not forwarded, and `dec_rom_hit` is 0.
- R6: A cycle at or above 100000h whose bits A[23:16] satisfy bottom ≤ A[23:16] ≤ top, inclusive at both ends, gives `dec_hole_hit`=1 and `dec_fwd`=0.
- R7: When top < bottom the hole never matches. This includes the reset values.
- R8: A cycle at or above 100000h that does not match the hole is forwarded, with both flags 0.
- R9: `dec_valid` is high in exactly the cycle after a cycle with `cyc_valid` high. In that cycle `dec_addr` holds the address captured with the strobe.
- R10: A decode strobed in the same cycle as a register write uses the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Configuration read byte for `cfg_addr` |
| cyc_valid | input | 1 | A memory cycle address is present |
| cyc_addr | input | 24 | ISA memory cycle address |
| dec_valid | output | 1 | Decision valid, one clock after `cyc_valid` |
| dec_addr | output | 24 | Address the decision belongs to |
| dec_fwd | output | 1 | Forward the cycle upstream |
| dec_rom_hit | output | 1 | An enabled ROM window matched |
| dec_hole_hit | output | 1 | The hole matched |

## Verification
A configuration write and a decode strobe can land on the same clock edge. The decision must then reflect the register contents from before the write. The bench provokes this in two ways. It closes the ROM window mask while a cycle to an open window is strobed, and it raises the hole top while a cycle is strobed into a region the hole is about to cover. The scoreboard computes the expected result from its own register copy before applying the write. Each clash is followed by a second strobe to the same address, which must show the new setting.

// File: rtl/isa_mem_fwd_decode.sv
module isa_mem_fwd_decode #(
  parameter int AW          = 24,
  parameter logic [7:0] OFF_ROM   = 8'h49,
  parameter logic [7:0] OFF_BOT   = 8'h4A,
  parameter logic [7:0] OFF_TOP   = 8'h4B,
  parameter logic [7:0] RST_ROM   = 8'h00,
  parameter logic [7:0] RST_BOT   = 8'h10,
  parameter logic [7:0] RST_TOP   = 8'h0F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    cfg_addr,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic          cyc_valid,
  input  logic [AW-1:0] cyc_addr,
  output logic          dec_valid,
  output logic [AW-1:0] dec_addr,
  output logic          dec_fwd,
  output logic          dec_rom_hit,
  output logic          dec_hole_hit
);

  localparam int SEG_LSB = AW - 8;

  logic [7:0] rom_en, hole_bot, hole_top;
  logic [7:0] seg;
  logic       above_1m, in_rom_range, rom_hit, hole_on, hole_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rom_en   <= RST_ROM;
      hole_bot <= RST_BOT;
      hole_top <= RST_TOP;
    end else if (cfg_we) begin
      case (cfg_addr)
        OFF_ROM: rom_en   <= cfg_wdata;
        OFF_BOT: hole_bot <= cfg_wdata;
        OFF_TOP: hole_top <= cfg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (cfg_addr)
      OFF_ROM: cfg_rdata = rom_en;
      OFF_BOT: cfg_rdata = hole_bot;
      OFF_TOP: cfg_rdata = hole_top;
      default: cfg_rdata = 8'h00;
    endcase
  end

  assign seg          = cyc_addr[AW-1:SEG_LSB];
  assign above_1m     = |cyc_addr[AW-1:20];
  assign in_rom_range = (cyc_addr[AW-1:17] == (AW-17)'(6));
  assign rom_hit      = in_rom_range && rom_en[cyc_addr[16:14]];
  assign hole_on      = hole_top >= hole_bot;
  assign hole_hit     = above_1m && hole_on && (seg >= hole_bot) && (seg <= hole_top);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid    <= 1'b0;
      dec_addr     <= '0;
      dec_fwd      <= 1'b0;
      dec_rom_hit  <= 1'b0;
      dec_hole_hit <= 1'b0;
    end else begin
      dec_valid <= cyc_valid;
      if (cyc_valid) begin
        dec_addr     <= cyc_addr;
        dec_rom_hit  <= rom_hit;
        dec_hole_hit <= hole_hit;
        dec_fwd      <= rom_hit || (above_1m && !hole_hit);
      end
    end
  end

  a_r2_bot_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == OFF_BOT |=> hole_bot == $past(cfg_wdata));
  a_r2_top_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == OFF_TOP |=> hole_top == $past(cfg_wdata));
  a_r3_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_addr != OFF_ROM && cfg_addr != OFF_BOT && cfg_addr != OFF_TOP |-> cfg_rdata == 8'h00);
  a_r6_hole_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_hole_hit |-> !dec_fwd && !dec_rom_hit);
  a_r4_rom_forwards: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_rom_hit |-> dec_fwd && dec_addr[AW-1:20] == '0);
  a_r7_hole_off: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && hole_top < hole_bot |=> !dec_hole_hit);
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |=> dec_valid && dec_addr == $past(cyc_addr));
  a_r9_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |=> !dec_valid);

endmodule

// File: tb/test_isa_mem_fwd_decode.sv
`timescale 1ns/1ps
module test_isa_mem_fwd_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic        cyc_valid = 1'b0;
  logic [23:0] cyc_addr = '0;
  logic        dec_valid;
  logic [23:0] dec_addr;
  logic        dec_fwd, dec_rom_hit, dec_hole_hit;

  always #2 clk = ~clk;

  isa_mem_fwd_decode i_isa_mem_fwd_decode (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cyc_valid(cyc_valid),
    .cyc_addr(cyc_addr), .dec_valid(dec_valid), .dec_addr(dec_addr),
    .dec_fwd(dec_fwd), .dec_rom_hit(dec_rom_hit), .dec_hole_hit(dec_hole_hit));

  typedef struct {
    logic [23:0] addr;
    logic [2:0]  flags;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  logic [7:0] m_rom = 8'h00, m_bot = 8'h10, m_top = 8'h0F;
  bit done = 0;

  function automatic logic [2:0] model(input logic [23:0] a);
    logic rom, hole, fwd;
    int n;
    rom = 0;
    if (a >= 24'h0C0000 && a < 24'h0E0000) begin
      n = int'((a - 24'h0C0000) / 24'h004000);
      rom = m_rom[n];
    end
    hole = (a >= 24'h100000) && (m_top >= m_bot) &&
           (a / 24'h010000 >= 24'(m_bot)) && (a / 24'h010000 <= 24'(m_top));
    fwd = rom || (a >= 24'h100000 && !hole);
    return {fwd, rom, hole};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [23:0] a, input string tag);
    exp_t e;
    e.addr = a; e.flags = model(a); e.tag = tag;
    q.push_back(e);
  endtask

  task automatic model_write(input logic [7:0] off, input logic [7:0] d);
    case (off)
      8'h49: m_rom = d;
      8'h4A: m_bot = d;
      8'h4B: m_top = d;
      default: ;
    endcase
  endtask

  task automatic wr(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk);
    cfg_addr = off; cfg_wdata = d; cfg_we = 1'b1;
    model_write(off, d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] off, input logic [7:0] e, input string tag);
    @(negedge clk);
    cfg_addr = off;
    #1;
    check(cfg_rdata === e, tag, 32'(cfg_rdata), 32'(e));
  endtask

  task automatic issue(input logic [23:0] a, input string tag);
    @(negedge clk);
    cyc_valid = 1'b1; cyc_addr = a;
    push(a, tag);
    @(negedge clk);
    cyc_valid = 1'b0;
  endtask

  task automatic issue_with_write(input logic [23:0] a, input logic [7:0] off,
                                  input logic [7:0] d, input string tag);
    @(negedge clk);
    cyc_valid = 1'b1; cyc_addr = a;
    cfg_addr = off; cfg_wdata = d; cfg_we = 1'b1;
    push(a, tag);
    model_write(off, d);
    @(negedge clk);
    cyc_valid = 1'b0; cfg_we = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && dec_valid) begin
      if (q.size() == 0) begin
        check(0, "R9 unexpected dec_valid", 32'(dec_addr), 32'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(dec_addr === e.addr, "R9 address", 32'(dec_addr), 32'(e.addr));
        check({dec_fwd, dec_rom_hit, dec_hole_hit} === e.flags, e.tag,
              32'({dec_fwd, dec_rom_hit, dec_hole_hit}), 32'(e.flags));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(dec_valid === 1'b0, "R1 dec_valid", 32'(dec_valid), 32'h0);
    rd(8'h49, 8'h00, "R1 mask reset");
    rd(8'h4A, 8'h10, "R1 bottom reset");
    rd(8'h4B, 8'h0F, "R1 top reset");

    wr(8'h50, 8'hFF);
    rd(8'h50, 8'h00, "R3 unmapped read");
    wr(8'h48, 8'hFF);
    rd(8'h49, 8'h00, "R3 mask untouched");
    rd(8'h4A, 8'h10, "R3 bottom untouched");

    issue(24'h0C4000, "R5 closed window");
    issue(24'h100000, "R7 reset hole off");
    issue(24'h0FFFFF, "R5 below 1MB");

    wr(8'h49, 8'h81);
    rd(8'h49, 8'h81, "R2 mask readback");
    issue(24'h0C0000, "R4 window0 start");
    issue(24'h0C3FFF, "R4 window0 end");
    issue(24'h0C4000, "R4 window1 closed");
    issue(24'h0DC000, "R4 window7 start");
    issue(24'h0DFFFF, "R4 window7 end");
    issue(24'h0E0000, "R5 above windows");
    issue(24'h0BFFFF, "R5 below windows");

    wr(8'h4A, 8'h10); wr(8'h4B, 8'h10);
    rd(8'h4B, 8'h10, "R2 top readback");
    issue(24'h100000, "R6 hole low edge");
    issue(24'h10FFFF, "R6 hole high edge");
    issue(24'h110000, "R8 past hole");

    wr(8'h4A, 8'h20); wr(8'h4B, 8'h21);
    issue(24'h1FFFFF, "R8 below hole");
    issue(24'h200000, "R6 hole start");
    issue(24'h21FFFF, "R6 hole end");
    issue(24'h220000, "R8 after hole");

    wr(8'h4B, 8'h1F);
    issue(24'h200000, "R7 top below bottom");

    issue_with_write(24'h0C0000, 8'h49, 8'h00, "R10 old mask");
    issue(24'h0C0000, "R10 new mask");
    issue_with_write(24'h800000, 8'h4B, 8'hFF, "R10 old top");
    issue(24'h800000, "R10 new top");

    wr(8'h4A, 8'hFF);
    issue(24'hFFFFFF, "R6 top of space");
    issue(24'hFEFFFF, "R8 just under hole");

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R9 pending results", 32'(q.size()), 32'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule